// File: doc/BRIEF.md
# Paged Open-Drain GPIO Register File

This block is the host-side register file of a 48-line digital I/O controller. The lines form six 8-bit ports, and the host reaches them through a byte-wide bus with a 4-bit address. For each line, a latch bit decides whether the pin sinks current (bit set) or is released to high impedance so that an external pull-up takes it high (bit clear). A line used as an input is simply left released. A read of a port returns the inverted, synchronized pin level.

A control byte holds a 2-bit page field and one write-lock bit for each port. The page field selects which bank appears in a three-byte window above the control byte. The bank is one of polarity, enable or interrupt-ID. The polarity and enable bytes are driven out to a separate edge-detect unit. That unit sets interrupt-ID bits through a set input. The host clears them by writing the ID bytes. A read-only pending byte summarizes which ID bytes have bits set.

Top module: `gpio_paged_regs`

## Requirements
- R1: After reset, every pin_sink_o bit is 0 (all pins released), the control byte at 0x07 reads 0x00, and the polarity, enable and ID registers are 0.
- R2: A bus write to port address k (0x00 to 0x05) whose lock bit is clear loads the byte into pin_sink_o[8k+7:8k] at the next clock edge. A 1 sinks the pin and a 0 releases it.
- R3: A read of port address k returns the inverse of pin_i[8k+7:8k], taken through a two-flop synchronizer. A pin change applied before edge n is visible on reads after edge n+1, and not after edge n.
- R4: Port addresses 0x00 to 0x05 are read and written identically on every page.
- R5: Address 0x07 reads back the byte last written. Bits 7:6 are the page number (1 polarity, 2 enable, 3 ID). Bit k (k = 0 to 5) is the write lock of port k.
- R6: While lock bit k is set, writes to port k leave pin_sink_o unchanged, and reads of port k still return the inverted pin level.
- R7: On page 1, addresses 0x08, 0x09 and 0x0A read and write polarity bytes 0, 1 and 2, which drive pol_o[7:0], [15:8] and [23:16].
- R8: On page 2, addresses 0x08 to 0x0A read and write enable bytes 0 to 2, which drive irq_en_o in the same byte order.
- R9: On page 3, addresses 0x08 to 0x0A read ID bytes 0 to 2. A 1 on id_set_i sets the matching ID bit at the next edge, and the bit holds until cleared. A host write replaces the byte. A set in the same cycle as a write wins.
- R10: On page 0, addresses 0x08 to 0x0A read 0x00, and writes there change no register.
- R11: Address 0x06 is read-only on every page. Bit b is the OR of ID byte b (b = 0 to 2), and bits 7:3 read 0. Writes to it have no effect.
- R12: Addresses 0x0B to 0x0F read 0x00, and bus_rdata_o is 0x00 whenever bus_sel_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from the address |
| pin_i | input | 48 | Pin levels, asynchronous |
| pin_sink_o | output | 48 | 1 enables the low-side sink on the pin |
| pol_o | output | 24 | Polarity bytes to the edge-detect unit |
| irq_en_o | output | 24 | Enable bytes to the edge-detect unit |
| id_set_i | input | 24 | Interrupt-ID set pulses from the edge-detect unit |

## Verification
Read data is combinational, so a read is sampled a short delay after the address is driven, with no clock edge between. Register writes and ID sets are due one edge after the strobe. The bench drives them at a falling edge and samples outputs at the next falling edge. Pin readback is due two edges after the pin changes. The bench therefore samples once after the first edge, where the old value must still show, and once after the second edge, where the new value must show.

// File: rtl/gpio_regs_pkg.sv
package gpio_regs_pkg;
  typedef enum logic [1:0] {
    PG_NONE = 2'd0,
    PG_POL  = 2'd1,
    PG_ENA  = 2'd2,
    PG_ID   = 2'd3
  } page_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 48,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '1;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank #(
  parameter int NUM_PORTS = 6,
  parameter int PORT_W    = 8,
  parameter int ADDR_W    = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [PORT_W-1:0]           wdata_i,
  input  logic [NUM_PORTS-1:0]        lock_i,
  output logic [NUM_PORTS*PORT_W-1:0] sink_o
);
  logic [PORT_W-1:0] lat_q [NUM_PORTS];

  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        lat_q[k] <= '0;
      else if (wr_i && addr_i == ADDR_W'(k) && !lock_i[k])
        lat_q[k] <= wdata_i;
    end
    assign sink_o[k*PORT_W +: PORT_W] = lat_q[k];
  end
endmodule

// File: rtl/gpio_aux_bank.sv
module gpio_aux_bank
  import gpio_regs_pkg::*;
#(
  parameter int AUX_BYTES = 3,
  parameter int PORT_W    = 8,
  parameter int ADDR_W    = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_i,
  input  logic                        hit_i,
  input  page_e                       page_i,
  input  logic [ADDR_W-1:0]           idx_i,
  input  logic [PORT_W-1:0]           wdata_i,
  input  logic [AUX_BYTES*PORT_W-1:0] id_set_i,
  output logic [AUX_BYTES*PORT_W-1:0] pol_o,
  output logic [AUX_BYTES*PORT_W-1:0] en_o,
  output logic [AUX_BYTES-1:0]        pend_o,
  output logic [PORT_W-1:0]           rdata_o
);
  logic [PORT_W-1:0] pol_q [AUX_BYTES];
  logic [PORT_W-1:0] en_q  [AUX_BYTES];
  logic [PORT_W-1:0] id_q  [AUX_BYTES];
  logic [AUX_BYTES-1:0] sel;

  for (genvar b = 0; b < AUX_BYTES; b++) begin : g_byte
    assign sel[b] = hit_i && idx_i == ADDR_W'(b);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pol_q[b] <= '0;
        en_q[b]  <= '0;
        id_q[b]  <= '0;
      end else begin
        if (wr_i && sel[b] && page_i == PG_POL) pol_q[b] <= wdata_i;
        if (wr_i && sel[b] && page_i == PG_ENA) en_q[b]  <= wdata_i;
        // set pulses win over a host clear in the same cycle
        id_q[b] <= ((wr_i && sel[b] && page_i == PG_ID) ? wdata_i : id_q[b])
                   | id_set_i[b*PORT_W +: PORT_W];
      end
    end

    assign pol_o[b*PORT_W +: PORT_W] = pol_q[b];
    assign en_o[b*PORT_W +: PORT_W]  = en_q[b];
    assign pend_o[b]                 = |id_q[b];
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < AUX_BYTES; b++) begin
      if (sel[b]) begin
        case (page_i)
          PG_POL:  rdata_o = pol_q[b];
          PG_ENA:  rdata_o = en_q[b];
          PG_ID:   rdata_o = id_q[b];
          default: rdata_o = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_paged_regs.sv
module gpio_paged_regs
  import gpio_regs_pkg::*;
#(
  parameter int NUM_PORTS   = 6,
  parameter int PORT_W      = 8,
  parameter int AUX_BYTES   = 3,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        bus_sel_i,
  input  logic                        bus_we_i,
  input  logic [ADDR_W-1:0]           bus_addr_i,
  input  logic [PORT_W-1:0]           bus_wdata_i,
  output logic [PORT_W-1:0]           bus_rdata_o,
  input  logic [NUM_PORTS*PORT_W-1:0] pin_i,
  output logic [NUM_PORTS*PORT_W-1:0] pin_sink_o,
  output logic [AUX_BYTES*PORT_W-1:0] pol_o,
  output logic [AUX_BYTES*PORT_W-1:0] irq_en_o,
  input  logic [AUX_BYTES*PORT_W-1:0] id_set_i
);
  localparam int LINES = NUM_PORTS * PORT_W;
  localparam logic [ADDR_W-1:0] PORT_END  = ADDR_W'(NUM_PORTS);
  localparam logic [ADDR_W-1:0] PEND_ADDR = ADDR_W'(NUM_PORTS);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_PORTS + 1);
  localparam logic [ADDR_W-1:0] AUX_BASE  = ADDR_W'(NUM_PORTS + 2);
  localparam logic [ADDR_W-1:0] AUX_END   = ADDR_W'(NUM_PORTS + 2 + AUX_BYTES);

  logic              wr;
  logic              port_hit, aux_hit;
  logic [PORT_W-1:0] ctrl_q;
  page_e             page;
  logic [LINES-1:0]  pin_sync, pin_rd;
  logic [AUX_BYTES-1:0] pend;
  logic [PORT_W-1:0] aux_rdata;
  logic [ADDR_W-1:0] aux_idx;

  assign wr       = bus_sel_i && bus_we_i;
  assign port_hit = bus_addr_i < PORT_END;
  assign aux_hit  = bus_addr_i >= AUX_BASE && bus_addr_i < AUX_END;
  assign aux_idx  = bus_addr_i - AUX_BASE;
  assign page     = page_e'(ctrl_q[PORT_W-1 -: 2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ctrl_q <= '0;
    else if (wr && bus_addr_i == CTRL_ADDR) ctrl_q <= bus_wdata_i;
  end

  gpio_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_sync)
  );

  assign pin_rd = ~pin_sync;

  gpio_port_bank #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .ADDR_W(ADDR_W)) u_ports (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr && port_hit),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .lock_i  (ctrl_q[NUM_PORTS-1:0]),
    .sink_o  (pin_sink_o)
  );

  gpio_aux_bank #(.AUX_BYTES(AUX_BYTES), .PORT_W(PORT_W), .ADDR_W(ADDR_W)) u_aux (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr),
    .hit_i    (aux_hit),
    .page_i   (page),
    .idx_i    (aux_idx),
    .wdata_i  (bus_wdata_i),
    .id_set_i (id_set_i),
    .pol_o    (pol_o),
    .en_o     (irq_en_o),
    .pend_o   (pend),
    .rdata_o  (aux_rdata)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (bus_sel_i) begin
      if (port_hit)                      bus_rdata_o = pin_rd[int'(bus_addr_i)*PORT_W +: PORT_W];
      else if (bus_addr_i == PEND_ADDR)  bus_rdata_o = PORT_W'(pend);
      else if (bus_addr_i == CTRL_ADDR)  bus_rdata_o = ctrl_q;
      else if (aux_hit)                  bus_rdata_o = aux_rdata;
    end
  end
endmodule

// File: rtl/gpio_paged_regs_chk.sv
module gpio_paged_regs_chk #(
  parameter int NUM_PORTS = 6,
  parameter int PORT_W    = 8,
  parameter int AUX_BYTES = 3,
  parameter int ADDR_W    = 4
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        bus_sel_i,
  input logic                        bus_we_i,
  input logic [ADDR_W-1:0]           bus_addr_i,
  input logic [PORT_W-1:0]           bus_wdata_i,
  input logic [PORT_W-1:0]           bus_rdata_o,
  input logic [NUM_PORTS*PORT_W-1:0] pin_sink_o,
  input logic [AUX_BYTES*PORT_W-1:0] pol_o,
  input logic [PORT_W-1:0]           ctrl_q
);
  localparam logic [ADDR_W-1:0] PORT_END  = ADDR_W'(NUM_PORTS);
  localparam logic [ADDR_W-1:0] PEND_ADDR = ADDR_W'(NUM_PORTS);
  localparam logic [ADDR_W-1:0] AUX_BASE  = ADDR_W'(NUM_PORTS + 2);
  localparam logic [ADDR_W-1:0] AUX_END   = ADDR_W'(NUM_PORTS + 2 + AUX_BYTES);

  logic [1:0]        pg;
  logic              port_wr, port_locked;
  logic [ADDR_W-1:0] addr_q;
  logic [PORT_W-1:0] sink_at_q;

  assign pg          = ctrl_q[PORT_W-1 -: 2];
  assign port_wr     = bus_sel_i && bus_we_i && bus_addr_i < PORT_END;
  assign port_locked = ctrl_q[bus_addr_i[2:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= bus_addr_i;
  end

  assign sink_at_q = (addr_q < PORT_END) ? pin_sink_o[int'(addr_q)*PORT_W +: PORT_W] : '0;

  assert_port_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_wr && !port_locked) |=> (sink_at_q == $past(bus_wdata_i)));

  assert_lock_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_wr && port_locked) |=> $stable(pin_sink_o));

  assert_pol_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_sel_i && bus_we_i && pg == 2'd1 && bus_addr_i == AUX_BASE)
      |=> (pol_o[PORT_W-1:0] == $past(bus_wdata_i)));

  assert_page0_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_sel_i && pg == 2'd0 && bus_addr_i >= AUX_BASE && bus_addr_i < AUX_END)
      |-> (bus_rdata_o == '0));

  assert_pend_upper_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_sel_i && bus_addr_i == PEND_ADDR) |-> (bus_rdata_o[PORT_W-1:AUX_BYTES] == '0));

  assert_unmapped_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_sel_i || bus_addr_i >= AUX_END) |-> (bus_rdata_o == '0));
endmodule

bind gpio_paged_regs gpio_paged_regs_chk #(
  .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .AUX_BYTES(AUX_BYTES), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_sel_i   (bus_sel_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .pin_sink_o  (pin_sink_o),
  .pol_o       (pol_o),
  .ctrl_q      (ctrl_q)
);

// File: tb/gpio_paged_regs_bench.sv
module gpio_paged_regs_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [47:0] pins = '1;
  logic [47:0] sink;
  logic [23:0] pol, ien;
  logic [23:0] idset = '0;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  gpio_paged_regs u_gpio_paged_regs (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pin_i(pins), .pin_sink_o(sink), .pol_o(pol), .irq_en_o(ien),
    .id_set_i(idset)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 sink", sink, 48'h0);
    chk("R1 pol", pol, 24'h0);
    chk("R1 en", ien, 24'h0);
    rd(4'h7, d); chk("R1 ctrl", d, 8'h00);
    wr(4'h7, 8'hC0); rd(4'h8, d); chk("R1 id0", d, 8'h00);
    wr(4'h7, 8'h00);
  endtask

  task automatic t_drive;
    wr(4'h0, 8'hA5); chk("R2 port0", sink[7:0], 8'hA5);
    wr(4'h5, 8'h3C); chk("R2 port5", sink[47:40], 8'h3C);
    chk("R2 others", sink[39:8], 32'h0);
    wr(4'h0, 8'h00); chk("R2 release", sink[7:0], 8'h00);
  endtask

  task automatic t_readback;
    logic [7:0] d;
    rd(4'h3, d); chk("R3 high reads 0", d, 8'h00);
    pins[31:24] = 8'h5A;
    @(negedge clk); rd(4'h3, d); chk("R3 not yet", d, 8'h00);
    @(negedge clk); rd(4'h3, d); chk("R3 synced", d, 8'hA5);
  endtask

  task automatic t_pages_port;
    logic [7:0] d;
    wr(4'h7, 8'hC0);
    wr(4'h2, 8'h81); chk("R4 write page3", sink[23:16], 8'h81);
    rd(4'h3, d); chk("R4 read page3", d, 8'hA5);
    wr(4'h7, 8'h40);
    wr(4'h2, 8'h00); chk("R4 write page1", sink[23:16], 8'h00);
  endtask

  task automatic t_ctrl;
    logic [7:0] d;
    wr(4'h7, 8'h85); rd(4'h7, d); chk("R5 readback", d, 8'h85);
    wr(4'h7, 8'h00);
  endtask

  task automatic t_lock;
    logic [7:0] d;
    wr(4'h1, 8'h0F);
    wr(4'h7, 8'h02);
    wr(4'h1, 8'hF0); chk("R6 locked", sink[15:8], 8'h0F);
    pins[15:8] = 8'h00;
    @(negedge clk); @(negedge clk);
    rd(4'h1, d); chk("R6 read locked", d, 8'hFF);
    wr(4'h0, 8'h11); chk("R6 other port", sink[7:0], 8'h11);
    wr(4'h7, 8'h00);
    wr(4'h1, 8'hF0); chk("R6 unlocked", sink[15:8], 8'hF0);
  endtask

  task automatic t_pol_en;
    logic [7:0] d;
    wr(4'h7, 8'h40);
    wr(4'h8, 8'h12); wr(4'h9, 8'h34); wr(4'hA, 8'h56);
    chk("R7 pol_o", pol, 24'h563412);
    rd(4'h9, d); chk("R7 read", d, 8'h34);
    wr(4'h7, 8'h80);
    wr(4'h8, 8'hAB); wr(4'hA, 8'hCD);
    chk("R8 en_o", ien, 24'hCD00AB);
    chk("R8 pol kept", pol, 24'h563412);
    rd(4'hA, d); chk("R8 read", d, 8'hCD);
  endtask

  task automatic t_id;
    logic [7:0] d;
    wr(4'h7, 8'hC0);
    @(negedge clk); idset = 24'h000200;
    @(negedge clk); idset = '0;
    @(negedge clk);
    rd(4'h9, d); chk("R9 set sticky", d, 8'h02);
    rd(4'h6, d); chk("R11 pending", d, 8'h02);
    wr(4'h6, 8'hFF);
    rd(4'h6, d); chk("R11 write ignored", d, 8'h02);
    rd(4'h7, d); chk("R11 ctrl intact", d, 8'hC0);
    wr(4'h9, 8'h00); rd(4'h9, d); chk("R9 clear", d, 8'h00);
    rd(4'h6, d); chk("R11 pending clear", d, 8'h00);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = 4'h9; wdata = 8'h00; idset = 24'h000400;
    @(negedge clk);
    sel = 1'b0; we = 1'b0; idset = '0;
    rd(4'h9, d); chk("R9 set wins", d, 8'h04);
  endtask

  task automatic t_page0;
    logic [7:0] d;
    wr(4'h7, 8'h00);
    rd(4'h8, d); chk("R10 read zero", d, 8'h00);
    wr(4'h8, 8'hFF); wr(4'h9, 8'hFF);
    chk("R10 pol unchanged", pol, 24'h563412);
    chk("R10 en unchanged", ien, 24'hCD00AB);
    wr(4'h7, 8'hC0); rd(4'h9, d); chk("R10 id unchanged", d, 8'h04);
  endtask

  task automatic t_unmapped;
    logic [7:0] d;
    rd(4'hB, d); chk("R12 0xB", d, 8'h00);
    rd(4'hF, d); chk("R12 0xF", d, 8'h00);
    addr = 4'h7; #1 chk("R12 unselected", rdata, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_drive();
    t_readback();
    t_pages_port();
    t_ctrl();
    t_lock();
    t_pol_en();
    t_id();
    t_page0();
    t_unmapped();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule